// File: doc/BRIEF.md
# One-Wire Byte Engine with Strong Pull-Up

This block moves whole bytes across a one-wire line. It sits above a bit-slot generator that handles the line timing. A command carries an operation code and a byte. The engine then breaks the operation into eight single-bit slot requests, least significant bit first. It waits for each slot to finish before issuing the next, and collects the line sample of every slot into a response byte.

Three operations are supported: write, read and touch. A read drives a one in every slot, so that the devices on the line can pull it low. A touch sends each bit of the command byte and returns, in its place, the bit seen on the line during that slot. A write drives the byte in the same way as a touch.

Some devices need extra current after a byte is written. For them, the engine holds a one-shot strong pull-up request, stored as a nonzero duration in millisecond ticks. The request is armed as the eighth bit of a write or touch goes out. The pull-up output then stays on until the requested number of ticks has passed after the last slot. After that the pull-up drops, the request is cleared and the operation completes.

Top module: `owire_byte_engine`

## Requirements
- R1: After reset, `cmd_ready` is high, and `slot_req`, `spu` and `rsp_valid` are low.
- R2: The operation codes are 0 for write, 1 for read and 2 for touch. For write and touch, slot i carries bit i of the command byte on `slot_bit`, with slot 0 holding the least significant bit.
- R3: A read issues eight slots with `slot_bit` high. Bit i of `rsp_byte` is the `slot_sample` value returned with the done pulse of slot i.
- R4: A touch or write returns in `rsp_byte` the eight sampled bits, with bit i taken from slot i.
- R5: `slot_req` is a single-cycle pulse. No new request is issued until `slot_done` has answered the previous one.
- R6: If a nonzero pull-up request is pending, `spu` goes high in the same cycle that the request for slot 7 of a write or touch is presented. `spu` is low during slots 0 to 6.
- R7: `spu` stays high until N `ms_tick` pulses have been seen after the done pulse of slot 7, where N is the requested duration. It then falls in the same cycle that `rsp_valid` rises.
- R8: A request is consumed by the write or touch that used it. A following write with no new request leaves `spu` low.
- R9: Setting a duration of zero cancels a pending request.
- R10: A read never raises `spu` and leaves a pending request in place for a later write.
- R11: `pu_set` is ignored while `cmd_ready` is low.
- R12: A command with operation code 3 is ignored: no slot is issued and `cmd_ready` stays high.
- R13: `rsp_valid` is a single-cycle pulse. `cmd_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_op | input | 2 | Operation code: 0 write, 1 read, 2 touch |
| cmd_byte | input | 8 | Byte to send |
| cmd_ready | output | 1 | Engine idle |
| pu_set | input | 1 | Load the pull-up request (only when idle) |
| pu_ms | input | 16 | Pull-up duration in ticks; 0 cancels |
| ms_tick | input | 1 | Millisecond tick pulse |
| slot_req | output | 1 | One-cycle request for a bit slot |
| slot_bit | output | 1 | Bit to drive in the requested slot |
| slot_done | input | 1 | Slot finished pulse |
| slot_sample | input | 1 | Line level sampled in the finished slot |
| spu | output | 1 | Strong pull-up enable |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_byte | output | 8 | Assembled sampled byte |

## Verification
The assertions assume that the slot generator returns exactly one `slot_done` pulse for each `slot_req`, and never sends one on its own. They also assume that `ms_tick` is a pulse, not a level. The bench acts as that slot generator: it answers each request after a fixed latency with one done pulse. It drives `ms_tick` only one cycle at a time, and raises `pu_set` while busy only to test that it is ignored.

// File: rtl/owbe_pkg.sv
package owbe_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_TOUCH = 2'd2,
        OP_RSVD  = 2'd3
    } owbe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HOLD,
        ST_DONE
    } owbe_state_e;

    typedef struct packed {
        logic req;
        logic bit_val;
    } slot_cmd_t;

    function automatic logic op_is_legal(owbe_op_e op);
        return op != OP_RSVD;
    endfunction

    function automatic logic op_sends_data(owbe_op_e op);
        return (op == OP_WRITE) || (op == OP_TOUCH);
    endfunction

endpackage

// File: rtl/owbe_shifter.sv
module owbe_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              sample,
    output logic              out_bit,
    output logic              pre_last,
    output logic              at_last,
    output logic [BYTE_W-1:0] data
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(BYTE_W - 2);

    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (shift_en) begin
            sh_q  <= {sample, sh_q[BYTE_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign out_bit  = sh_q[0];
    assign pre_last = (idx_q == PRE_IDX);
    assign at_last  = (idx_q == LAST_IDX);
    assign data     = sh_q;
endmodule

// File: rtl/owbe_pullup.sv
module owbe_pullup #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             set_req,
    input  logic [DUR_W-1:0] set_val,
    input  logic             arm,
    input  logic             hold_en,
    input  logic             ms_tick,
    output logic             spu,
    output logic             hold_done
);
    logic [DUR_W-1:0] pend_q;
    logic [DUR_W-1:0] cnt_q;
    logic             spu_q;

    assign hold_done = hold_en && spu_q && ms_tick && (cnt_q == DUR_W'(1));
    assign spu       = spu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
            spu_q  <= 1'b0;
        end else begin
            if (idle && set_req)
                pend_q <= set_val;
            if (arm && pend_q != '0) begin
                spu_q <= 1'b1;
                cnt_q <= pend_q;
            end
            if (hold_done) begin
                spu_q  <= 1'b0;
                pend_q <= '0;
            end else if (hold_en && spu_q && ms_tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: a live pull-up always has ticks left to count
    p_cnt_live_r7: assert property (@(posedge clk) disable iff (rst)
        spu_q |-> (cnt_q != '0));
    // R11: the request does not change while busy unless consumed
    p_busy_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (!idle && !hold_done) |=> $stable(pend_q));
endmodule

// File: rtl/owbe_ctrl.sv
module owbe_ctrl
    import owbe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  owbe_op_e cmd_op,
    input  logic     slot_done,
    input  logic     pre_last,
    input  logic     at_last,
    input  logic     spu,
    input  logic     hold_done,
    output logic     ready,
    output logic     load,
    output logic     shift_en,
    output logic     arm,
    output logic     hold_en,
    output logic     slot_req,
    output logic     rsp_valid
);
    owbe_state_e st_q, st_d;
    owbe_op_e    op_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_valid && op_is_legal(cmd_op)) st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_WAIT;
            ST_WAIT:  if (slot_done) begin
                          if (!at_last)  st_d = ST_ISSUE;
                          else if (spu)  st_d = ST_HOLD;
                          else           st_d = ST_DONE;
                      end
            ST_HOLD:  if (hold_done) st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            op_q <= OP_WRITE;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && cmd_valid)
                op_q <= cmd_op;
        end
    end

    assign ready     = (st_q == ST_IDLE);
    assign load      = ready && cmd_valid && op_is_legal(cmd_op);
    assign shift_en  = (st_q == ST_WAIT) && slot_done;
    assign arm       = shift_en && pre_last && op_sends_data(op_q);
    assign hold_en   = (st_q == ST_HOLD);
    assign slot_req  = (st_q == ST_ISSUE);
    assign rsp_valid = (st_q == ST_DONE);

    // R5: a request lasts one cycle
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        slot_req |=> !slot_req);
    // R13: completion pulse lasts one cycle and is followed by idle
    p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && ready));
endmodule

// File: rtl/owire_byte_engine.sv
module owire_byte_engine
    import owbe_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DUR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_ready,
    input  logic              pu_set,
    input  logic [DUR_W-1:0]  pu_ms,
    input  logic              ms_tick,
    output logic              slot_req,
    output logic              slot_bit,
    input  logic              slot_done,
    input  logic              slot_sample,
    output logic              spu,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);
    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    owbe_op_e          op_in;
    logic              load, shift_en, arm, hold_en, hold_done;
    logic              pre_last, at_last, out_bit;
    logic [BYTE_W-1:0] load_val;
    slot_cmd_t         slot_cmd;

    assign op_in    = owbe_op_e'(cmd_op);
    assign load_val = (op_in == OP_READ) ? ALL_ONES : cmd_byte;

    owbe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_in),
        .slot_done (slot_done),
        .pre_last  (pre_last),
        .at_last   (at_last),
        .spu       (spu),
        .hold_done (hold_done),
        .ready     (cmd_ready),
        .load      (load),
        .shift_en  (shift_en),
        .arm       (arm),
        .hold_en   (hold_en),
        .slot_req  (slot_cmd.req),
        .rsp_valid (rsp_valid)
    );

    owbe_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .shift_en (shift_en),
        .sample   (slot_sample),
        .out_bit  (out_bit),
        .pre_last (pre_last),
        .at_last  (at_last),
        .data     (rsp_byte)
    );

    owbe_pullup #(.DUR_W(DUR_W)) u_pull (
        .clk       (clk),
        .rst       (rst),
        .idle      (cmd_ready),
        .set_req   (pu_set),
        .set_val   (pu_ms),
        .arm       (arm),
        .hold_en   (hold_en),
        .ms_tick   (ms_tick),
        .spu       (spu),
        .hold_done (hold_done)
    );

    assign slot_cmd.bit_val = out_bit;
    assign slot_req         = slot_cmd.req;
    assign slot_bit         = slot_cmd.bit_val;

    // R6: no pull-up while an early slot is being requested
    p_spu_late_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_req && !at_last) |-> !spu);
    // R7: the pull-up drops exactly when the operation completes
    p_spu_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(spu) |-> rsp_valid);
    // R1, R13: no slot activity while idle
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!slot_req && !spu));
endmodule

// File: tb/owire_byte_engine_tb.sv
module owire_byte_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_byte = 8'd0;
    logic        cmd_ready;
    logic        pu_set = 1'b0;
    logic [15:0] pu_ms = 16'd0;
    logic        ms_tick = 1'b0;
    logic        slot_req, slot_bit;
    logic        slot_done = 1'b0;
    logic        slot_sample = 1'b0;
    logic        spu, rsp_valid;
    logic [7:0]  rsp_byte;

    int total = 0;
    int bad = 0;
    int pend_model = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    owire_byte_engine u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .pu_set(pu_set),
        .pu_ms(pu_ms), .ms_tick(ms_tick), .slot_req(slot_req),
        .slot_bit(slot_bit), .slot_done(slot_done), .slot_sample(slot_sample),
        .spu(spu), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pull(input int dur);
        @(negedge clk);
        pu_set = 1'b1; pu_ms = 16'(dur);
        @(negedge clk);
        pu_set = 1'b0;
        pend_model = dur;
    endtask

    // op: 0 write, 1 read, 2 touch
    task automatic run_op(input int op, input logic [7:0] b, input logic [7:0] smp,
                          input bit poke_busy);
        bit use_pu;
        bit got;
        int seen_bits;
        use_pu = (op != 1) && (pend_model != 0);
        seen_bits = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            got = 1'b0;
            for (int w = 0; w < 50 && !got; w++) begin
                if (slot_req) got = 1'b1;
                else @(negedge clk);
            end
            check(got, "R5 slot request", int'(got), 1);
            seen_bits[i] = slot_bit;
            check(slot_bit == ((op == 1) ? 1'b1 : b[i]), (op == 1) ? "R3 read drives one" : "R2 slot bit order",
                  int'(slot_bit), int'((op == 1) ? 1'b1 : b[i]));
            if (i == 7)
                check(spu == use_pu, (op == 1) ? "R10 read no pull-up" : "R6 pull-up at slot 7",
                      int'(spu), int'(use_pu));
            else
                check(spu == 1'b0, "R6 no pull-up early", int'(spu), 0);
            @(negedge clk);
            if (poke_busy && i == 3) begin
                pu_set = 1'b1; pu_ms = 16'd5;
            end
            check(!slot_req, "R5 single pulse", int'(slot_req), 0);
            @(negedge clk);
            pu_set = 1'b0;
            check(!slot_req, "R5 wait for done", int'(slot_req), 0);
            slot_done = 1'b1; slot_sample = smp[i];
            @(negedge clk);
            slot_done = 1'b0; slot_sample = 1'b0;
        end
        if (use_pu) begin
            for (int t = 0; t < pend_model; t++) begin
                check(spu && !rsp_valid, "R7 pull-up held", int'(spu), 1);
                ms_tick = 1'b1;
                @(negedge clk);
                ms_tick = 1'b0;
            end
            pend_model = 0;
            check(!spu && rsp_valid, "R7 pull-up drop with done", int'(spu), 0);
        end
        got = 1'b0;
        for (int w = 0; w < 20 && !got; w++) begin
            if (rsp_valid) got = 1'b1;
            else @(negedge clk);
        end
        check(got, "R13 completion", int'(got), 1);
        check(rsp_byte == smp, (op == 1) ? "R3 read byte" : "R4 sampled byte",
              int'(rsp_byte), int'(smp));
        @(negedge clk);
        check(!rsp_valid && cmd_ready, "R13 pulse then ready", int'(rsp_valid), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !slot_req && !spu && !rsp_valid, "R1 reset state",
              {cmd_ready, slot_req, spu, rsp_valid}, 4'b1000);

        run_op(0, 8'hA5, 8'hA5, 1'b0);             // R2 write, R4
        run_op(1, 8'h00, 8'h3C, 1'b0);             // R3 read
        run_op(2, 8'h96, 8'h5A, 1'b0);             // R4 touch
        set_pull(3);
        run_op(0, 8'h81, 8'h81, 1'b0);             // R6 R7
        run_op(0, 8'h7E, 8'h7E, 1'b0);             // R8 consumed
        set_pull(2);
        set_pull(0);
        run_op(0, 8'hF0, 8'hF0, 1'b0);             // R9 cancel
        set_pull(2);
        run_op(1, 8'h00, 8'hC3, 1'b0);             // R10 read keeps request
        run_op(0, 8'h0F, 8'h0F, 1'b0);             // R10 then write uses it
        set_pull(1);
        run_op(2, 8'h33, 8'h55, 1'b0);             // R6 R7 touch
        run_op(0, 8'h12, 8'h12, 1'b1);             // R11 pu_set while busy
        run_op(0, 8'h34, 8'h34, 1'b0);             // R11 no pull-up after
        // R12: reserved code
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_byte = 8'hFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check(cmd_ready && !slot_req, "R12 reserved ignored", int'(slot_req), 0);
            @(negedge clk);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule